// File: doc/BRIEF.md
# Two-Wire Block-Transfer Configuration Slave

This block is a serial configuration target for a clock-generation subsystem. It holds six 8-bit configuration bytes and presents them to the clock logic as one flat bus. A host on a two-wire serial bus (clock line plus open-drain data line) writes all the bytes or only a leading part of them in a single block transfer. It can also read all of them back in a single block transfer.

A write transfer has the following sequence. The host sends START and the write address 0xD2. It then sends two header bytes, a command code and a byte count. The slave acknowledges both header bytes and discards their contents. After the header the host sends data bytes. These load the register bytes in order, starting at byte 0, until STOP. A read transfer starts with address 0xD3. The slave answers with a byte count of 6 and then with bytes 0 upward, and the host acknowledges each byte.

Both lines are oversampled by the system clock, which must run at least ten times faster than the serial clock. The data line is modelled as an input plus an active-high pull-low enable. Three pins are sampled while reset is held. Three read-only bits of byte 4 report these captured values in inverted form.

Top module: `cfgs_top`

## Requirements
- R1: After reset, byte 0 reads 0x30 (its four frequency bits, at positions 2,6,5,4, hold 0,0,1,1). Bytes 1, 2, 3 and 5 read 0xFF. The writable bits of byte 4 (bits 7,6,4,2,0) read 1.
- R2: The address byte 0xD2 (write) and the address byte 0xD3 (read) are acknowledged. Any other address is not acknowledged, and no byte is acknowledged or stored after it until the next START.
- R3: In a write, the two bytes after the address are acknowledged and discarded. Each following data byte is acknowledged and stored, in order, into byte 0, byte 1, and so on.
- R4: A STOP after any complete data byte keeps the bytes already written and leaves the rest unchanged. A byte cut short by STOP (STOP during the high phase of its eighth bit included) is not stored.
- R5: Data bytes beyond byte 5 are acknowledged, but they change no register.
- R6: In a read, the first byte sent is the count 6. Bytes 0 to 5 follow in order, and any later byte reads 0xFF. Bits go out most significant first.
- R7: When the host does not acknowledge a read byte, the slave stops driving the data line until the next START.
- R8: Bits 5, 3 and 1 of byte 4 report the inversion of strap inputs 2, 1 and 0 as captured while reset is asserted. Writes to these bits and later strap changes have no effect on them.
- R9: The slave changes its drive of the data line only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the serial clock rate |
| rst_n | input | 1 | Active-low reset; the strap pins are captured while it is low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, the slave pulls the data line low |
| strap_i | input | 3 | Strap pins, captured during reset |
| cfg_o | output | 48 | Configuration bytes; byte k sits at bits 8k+7..8k |

## Verification
A data byte is complete at the rising clock edge of its eighth bit. The slave stores it only at the falling edge that follows. A STOP condition can therefore arrive while a completed byte is still pending, and STOP then takes priority and the byte is dropped. The bench provokes this by driving the eighth bit low, raising the clock, and releasing the data line while the clock is still high. The bench judges the outcome by comparing the register bus with its model on every clock, and expects the bus to be unchanged. A four-bit cut-off is checked the same way. A write that ends after only two data bytes confirms that a STOP at a byte boundary does not undo bytes already stored.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int BYTE_W     = 8;
  localparam int STRAP_W    = 3;
  localparam int STRAP_BYTE = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RXACK,
    PH_TX,
    PH_TXACK
  } phase_t;

  // Power-on value of configuration byte idx.
  function automatic logic [BYTE_W-1:0] reset_byte(input int idx);
    return (idx == 0) ? 8'h30 : 8'hFF;
  endfunction

  // Bits a host write may change in byte idx.
  function automatic logic [BYTE_W-1:0] write_mask(input int idx);
    return (idx == STRAP_BYTE) ? 8'hD5 : 8'hFF;
  endfunction

  // Read-only strap bits placed into their byte, inverted.
  function automatic logic [BYTE_W-1:0] strap_field(input logic [STRAP_W-1:0] s);
    logic [BYTE_W-1:0] f;
    f    = '0;
    f[5] = ~s[2];
    f[3] = ~s[1];
    f[1] = ~s[0];
    return f;
  endfunction

  function automatic logic [BYTE_W-1:0] merge_byte(input logic [BYTE_W-1:0] old_v,
                                                   input logic [BYTE_W-1:0] new_v,
                                                   input logic [BYTE_W-1:0] mask);
    return (new_v & mask) | (old_v & ~mask);
  endfunction
endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '1;
        else        stage[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '1;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/cfgs_cond_detect.sv
module cfgs_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c,
  output logic scl_lvl,
  output logic sda_lvl
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_lvl  = scl_s;
  assign sda_lvl  = sda_s;
endmodule

// File: rtl/cfgs_proto.sv
module cfgs_proto
  import cfgs_pkg::*;
#(
  parameter logic [7:0] WR_ADDR   = 8'hD2,
  parameter logic [7:0] RD_ADDR   = 8'hD3,
  parameter int         NUM_BYTES = 6,
  parameter int         IDX_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_c,
  input  logic             stop_c,
  input  logic             sda_lvl,
  input  logic [7:0]       rd_byte,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             slv_idle
);
  localparam logic [IDX_W-1:0] HDR_BYTES = IDX_W'(2);
  localparam logic [7:0]       CNT_BYTE  = 8'(NUM_BYTES);

  phase_t           phase;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic             pending, addr_ph, is_read, nack, oe_q;
  logic [IDX_W-1:0] rx_no, tx_no;
  logic             byte_end;

  function automatic logic addr_ok(input logic [7:0] b);
    return (b == WR_ADDR) || (b == RD_ADDR);
  endfunction

  function automatic logic [IDX_W-1:0] sat_inc(input logic [IDX_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  assign byte_end = (phase == PH_RX) && scl_fall && pending && !start_c && !stop_c;
  assign wr_stb   = byte_end && !addr_ph && (rx_no >= HDR_BYTES);
  assign wr_idx   = rx_no - HDR_BYTES;
  assign wr_data  = shreg;
  assign rd_idx   = tx_no;
  assign slv_idle = (phase == PH_IDLE);
  assign sda_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      pending <= 1'b0;
      addr_ph <= 1'b0;
      is_read <= 1'b0;
      nack    <= 1'b0;
      oe_q    <= 1'b0;
      rx_no   <= '0;
      tx_no   <= '0;
    end else if (start_c) begin
      phase   <= PH_RX;
      bitcnt  <= '0;
      pending <= 1'b0;
      addr_ph <= 1'b1;
      rx_no   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_c) begin
      phase   <= PH_IDLE;
      pending <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) pending <= 1'b1;
          end
          if (byte_end) begin
            pending <= 1'b0;
            bitcnt  <= '0;
            if (addr_ph) begin
              addr_ph <= 1'b0;
              if (addr_ok(shreg)) begin
                is_read <= (shreg == RD_ADDR);
                oe_q    <= 1'b1;
                phase   <= PH_RXACK;
              end else begin
                phase   <= PH_IDLE;
              end
            end else begin
              oe_q  <= 1'b1;
              phase <= PH_RXACK;
              rx_no <= sat_inc(rx_no);
            end
          end
        end
        PH_RXACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (is_read) begin
              shreg <= CNT_BYTE;
              oe_q  <= ~CNT_BYTE[7];
              tx_no <= '0;
              phase <= PH_TX;
            end else begin
              oe_q  <= 1'b0;
              phase <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              oe_q   <= 1'b0;
              bitcnt <= '0;
              phase  <= PH_TXACK;
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              oe_q  <= ~shreg[6];
            end
          end
        end
        PH_TXACK: begin
          if (scl_rise) nack <= sda_lvl;
          if (scl_fall) begin
            if (nack) begin
              phase <= PH_IDLE;
            end else begin
              shreg <= rd_byte;
              oe_q  <= ~rd_byte[7];
              tx_no <= sat_inc(tx_no);
              phase <= PH_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile
  import cfgs_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int IDX_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [STRAP_W-1:0]          strap_i,
  input  logic                        wr_stb,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [7:0]                  wr_data,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [7:0]                  rd_byte,
  output logic [NUM_BYTES*BYTE_W-1:0] cfg_o
);
  logic [STRAP_W-1:0] strap_q;
  logic [BYTE_W-1:0]  regs [NUM_BYTES];

  // Straps follow the pins only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= reset_byte(i) & write_mask(i);
      else if (wr_stb && (wr_idx == IDX_W'(i)))
        regs[i] <= merge_byte(regs[i], wr_data, write_mask(i));
    end
    if (i == STRAP_BYTE) begin : g_ro
      assign cfg_o[i*BYTE_W +: BYTE_W] = regs[i] | strap_field(strap_q);
    end else begin : g_rw
      assign cfg_o[i*BYTE_W +: BYTE_W] = regs[i];
    end
  end

  always_comb begin
    rd_byte = 8'hFF;
    for (int i = 0; i < NUM_BYTES; i++)
      if (rd_idx == IDX_W'(i)) rd_byte = cfg_o[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/cfgs_top.sv
module cfgs_top
  import cfgs_pkg::*;
#(
  parameter logic [7:0] WR_ADDR     = 8'hD2,
  parameter logic [7:0] RD_ADDR     = 8'hD3,
  parameter int         NUM_BYTES   = 6,
  parameter int         SYNC_STAGES = 2,
  parameter int         IDX_W       = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe,
  input  logic [STRAP_W-1:0]          strap_i,
  output logic [NUM_BYTES*BYTE_W-1:0] cfg_o
);
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_c, stop_c, scl_lvl, sda_lvl;
  logic             wr_stb, slv_idle;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_byte;

  cfgs_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout({scl_s, sda_s})
  );

  cfgs_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c),
    .stop_c(stop_c), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
  );

  cfgs_proto #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR),
               .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c), .sda_lvl(sda_lvl), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .slv_idle(slv_idle)
  );

  cfgs_regfile #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .wr_stb(wr_stb),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_byte(rd_byte),
    .cfg_o(cfg_o)
  );
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker
  import cfgs_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int IDX_W     = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sda_oe,
  input logic                        scl_lvl,
  input logic                        slv_idle,
  input logic                        wr_stb,
  input logic [IDX_W-1:0]            wr_idx,
  input logic [NUM_BYTES*BYTE_W-1:0] cfg_o
);
  localparam int RO_BASE = STRAP_BYTE * BYTE_W;

  // R2 / R7: an idle slave never pulls the data line
  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    slv_idle |-> !sda_oe);

  // R3: every stored byte is followed by an acknowledge
  a_r3_store_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> sda_oe);

  // R5: stores aimed past the last byte leave the bus unchanged
  a_r5_overflow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_idx >= IDX_W'(NUM_BYTES))) |=> $stable(cfg_o));

  // R8: strap-reporting bits never move once out of reset
  a_r8_strap_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable({cfg_o[RO_BASE+5], cfg_o[RO_BASE+3], cfg_o[RO_BASE+1]}));

  // R9: the data drive changes only with the clock line low
  a_r9_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_lvl);
endmodule

bind cfgs_top cfgs_checker #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
  .slv_idle(slv_idle), .wr_stb(wr_stb), .wr_idx(wr_idx), .cfg_o(cfg_o)
);

// File: tb/sim_cfgs_top.sv
module sim_cfgs_top;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n, host_scl, host_sda, scl_seen, oe_prev, live;
  logic [2:0]  strap;
  logic [47:0] cfg;
  logic        sda_oe;
  logic [7:0]  mreg [6];
  logic [7:0]  payload [$];
  int          n_cmp = 0, n_bad = 0, cyc = 0;

  wire sda_line = host_sda & ~sda_oe;

  always #5 clk = ~clk;

  cfgs_top u0 (.clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
               .sda_oe(sda_oe), .strap_i(strap), .cfg_o(cfg));

  function automatic logic [47:0] mbus();
    logic [47:0] b;
    for (int i = 0; i < 6; i++) b[i*8 +: 8] = mreg[i];
    return b;
  endfunction

  function automatic void model_write(input int idx, input logic [7:0] d);
    logic [7:0] m;
    if (idx < 6) begin
      m = (idx == 4) ? 8'hD5 : 8'hFF;
      mreg[idx] = (d & m) | (mreg[idx] & ~m);
    end
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference comparison on every clock of a high serial-clock phase
  always @(posedge clk) scl_seen <= host_scl;
  always @(negedge clk) begin
    if (live && scl_seen) begin
      n_cmp++;
      if (cfg !== mbus()) begin
        n_bad++;
        $display("FAIL R3/R4 bus actual=%h expected=%h", cfg, mbus());
      end
      if (sda_oe !== oe_prev) begin
        n_bad++;
        $display("FAIL R9 drive changed with clock high actual=%b expected=%b", sda_oe, oe_prev);
      end
    end
    oe_prev = sda_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wq(Q); host_sda = 1'b0; wq(Q); host_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(Q); host_scl = 1'b1; wq(Q); host_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit upd, input int idx, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wq(Q); host_scl = 1'b1; wq(2*Q); host_scl = 1'b0; wq(Q);
    end
    host_sda = 1'b1; wq(Q);
    host_scl = 1'b1;
    if (upd) model_write(idx, b);
    wq(Q); acked = !sda_line; wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); host_scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); host_scl = 1'b0; wq(Q);
    end
    host_sda = nack; wq(Q); host_scl = 1'b1; wq(2*Q); host_scl = 1'b0; wq(Q);
    host_sda = 1'b1;
  endtask

  // Header then payload; expects acknowledges everywhere
  task automatic wr_txn(input string tag);
    bit a;
    bus_start();
    send_byte(8'hD2, 0, 0, a);   chk({tag, " R2 write address ack"}, 48'(a), 48'd1);
    send_byte(8'h5A, 0, 0, a);   chk({tag, " R3 command ack"}, 48'(a), 48'd1);
    send_byte(8'h06, 0, 0, a);   chk({tag, " R3 count ack"}, 48'(a), 48'd1);
    foreach (payload[k]) begin
      send_byte(payload[k], 1, k, a);
      chk({tag, (k < 6) ? " R3 data ack" : " R5 extra data ack"}, 48'(a), 48'd1);
    end
    bus_stop();
  endtask

  // Read count plus n bytes (NACK on the last), then probe release
  task automatic rd_txn(input int n, input string tag);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, 0, 0, a);   chk({tag, " R2 read address ack"}, 48'(a), 48'd1);
    recv_byte(n == 0, b);        chk({tag, " R6 count"}, 48'(b), 48'd6);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, b);
      chk({tag, " R6 read byte"}, 48'(b), 48'((k < 6) ? mreg[k] : 8'hFF));
    end
    for (int p = 0; p < 9; p++) begin
      wq(Q); host_scl = 1'b1; wq(Q);
      chk({tag, " R7 released after NACK"}, 48'(sda_line), 48'd1);
      wq(Q); host_scl = 1'b0; wq(Q);
    end
    bus_stop();
  endtask

  // Header, then nbits of b with the last bit low, then STOP while the clock is high
  task automatic cut_txn(input logic [7:0] b, input int nbits);
    bit a;
    bus_start();
    send_byte(8'hD2, 0, 0, a);
    send_byte(8'h00, 0, 0, a);
    send_byte(8'h06, 0, 0, a);
    for (int k = 0; k < nbits - 1; k++) begin
      host_sda = b[7-k]; wq(Q); host_scl = 1'b1; wq(2*Q); host_scl = 1'b0; wq(Q);
    end
    host_sda = 1'b0; wq(Q); host_scl = 1'b1; wq(Q); host_sda = 1'b1; wq(2*Q);
  endtask

  initial begin
    bit a;
    host_scl = 1'b1; host_sda = 1'b1; strap = 3'b101; rst_n = 1'b0;
    live = 1'b0; oe_prev = 1'b0;
    mreg = '{8'h30, 8'hFF, 8'hFF, 8'hFF, 8'hDD, 8'hFF};
    wq(5); rst_n = 1'b1; wq(2);
    strap = 3'b010;
    chk("R1 reset bytes", cfg, 48'hFF_DD_FF_FF_FF_30);
    chk("R1 reset no drive", 48'(sda_oe), 48'd0);
    live = 1'b1;

    payload = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    wr_txn("full");
    chk("R5 bytes after overflow", cfg, 48'h66_5D_44_33_22_11);

    rd_txn(7, "readall");

    payload = '{8'hA0, 8'hB1};
    wr_txn("short");
    chk("R4 short write keeps tail", cfg, 48'h66_5D_44_33_B1_A0);

    cut_txn(8'hFE, 8);
    chk("R4 stop on eighth bit", cfg, mbus());
    cut_txn(8'hC0, 4);
    chk("R4 stop mid byte", cfg, 48'h66_5D_44_33_B1_A0);

    bus_start();
    send_byte(8'hA4, 0, 0, a);   chk("R2 foreign address nack", 48'(a), 48'd0);
    send_byte(8'hD2, 0, 0, a);   chk("R2 ignored until START", 48'(a), 48'd0);
    send_byte(8'h99, 0, 0, a);   chk("R2 data ignored", 48'(a), 48'd0);
    bus_stop();
    chk("R2 nothing stored", cfg, 48'h66_5D_44_33_B1_A0);

    payload = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_txn("ro");
    chk("R8 strap bits survive zero write", 48'(cfg[39:32]), 48'h08);

    rd_txn(1, "short read");
    rd_txn(0, "count only");
    rd_txn(6, "final read");
    chk("R6 final bus", cfg, 48'h66_08_00_00_00_00);

    live = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule